// File: doc/BRIEF.md
# Three-wire serial EEPROM sweep reader

This block reads every 16-bit word of a small three-wire serial EEPROM with a 6-bit word address, once per start request. It drives the memory's chip select, serial clock and serial data-in pins, and samples its serial data-out pin. A start pulse received while the block is idle begins a sweep over word addresses 0 to 63 in ascending order. Each word read is a separate frame. Chip select rises first. A start bit of 1 follows, then the read opcode, then the address. Sixteen data bits are then shifted in. The frame closes with chip select dropped and one trailing clock pulse.

Each word goes out as a one-cycle strobe that carries its address and data. The block also keeps a wrapping 16-bit sum of all the words. When the sweep ends, a done flag rises and a pass flag reports whether the sum equals the fixed signature. All pin timing comes from a step divider. The parameter `STEP_DIV` gives the number of system clock cycles per pin step, so the system clock frequency in MHz gives a 1 microsecond step.

Top module: `uwire_eeprom_reader`

## Requirements
- R1: After reset, and whenever the block is idle, chip select, serial clock and data-in are low, and busy, done, checksum_ok and word_valid are low.
- R2: A start pulse while idle sets busy and reads words 0 to 63 in ascending order. Each frame starts with one step that raises chip select. Nine bits then go out on data-in, most significant first: the start bit 1, the opcode bits 1 then 0, and the six address bits. For each bit, data-in is set in one step, the serial clock goes high in the next step, and the clock goes low in the step after that.
- R3: After the address, sixteen data bits are received most significant first. For each bit, the serial clock goes high for one step. Data-out is sampled at the end of that step, on the same step boundary at which the clock falls.
- R4: Each frame ends with one step that drives chip select and data-in low, followed by one step with the serial clock high and one step with it low. A frame therefore lasts 63 steps.
- R5: Pin levels change only on step boundaries. Step boundaries fall every STEP_DIV clock cycles, counted from the cycle in which the start was accepted. Each level therefore holds for at least STEP_DIV cycles.
- R6: word_valid_o is high for exactly one cycle per word. That cycle comes right after the boundary where the word's last bit is sampled. word_addr_o and word_data_o carry the word's address and data on that cycle.
- R7: checksum_ok_o is high exactly when done_o is high and the 16-bit wrapping sum of the 64 words read equals SIGNATURE (0xBABA by default).
- R8: At the last step of the final frame, busy_o falls and done_o rises in the same cycle. done_o stays high until the next accepted start.
- R9: A start pulse while busy is ignored. The sweep continues unchanged.
- R10: An accepted start clears done_o and the running sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sweep; used only while idle |
| eep_do_i | input | 1 | Serial data from the EEPROM |
| eep_cs_o | output | 1 | EEPROM chip select |
| eep_sk_o | output | 1 | EEPROM serial clock |
| eep_di_o | output | 1 | Serial data toward the EEPROM |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished; held until the next start |
| checksum_ok_o | output | 1 | Sum of all words equals the signature |
| word_valid_o | output | 1 | One-cycle strobe for a received word |
| word_addr_o | output | ADDR_W | Address of the strobed word |
| word_data_o | output | DATA_W | Data of the strobed word |

## Verification
The bench builds the block with STEP_DIV = 3 and keeps the default address width, word width, word count and signature. A divider of three leaves two held cycles between boundaries. Both the hold rule and the exact boundary cycle can therefore be compared on every clock, and the divider counter wraps at a limit that is not a power of two. With this step length, a full 64-word sweep of 4032 steps takes about twelve thousand cycles. Several complete sweeps then fit in one run, which covers a passing sum, a failing sum, sums that wrap past 16 bits, and a restart after done.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_CMD_SET,
    ST_CMD_HI,
    ST_CMD_LO,
    ST_DAT_HI,
    ST_DAT_LO,
    ST_END_DROP,
    ST_END_HI,
    ST_END_LO
  } seq_state_e;

  localparam logic [1:0] READ_OP = 2'b10;
endpackage

// File: rtl/uwr_step_timer.sv
module uwr_step_timer #(
  parameter int unsigned STEP_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/uwr_frame_seq.sv
module uwr_frame_seq
  import uwr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_WORDS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              do_i,
  output logic              busy_o,
  output logic              launch_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              done_o,
  output logic              word_valid_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [DATA_W-1:0] word_data_o
);
  localparam int unsigned CMD_W = 3 + ADDR_W;  // start bit, opcode, address
  localparam int unsigned BC_W  = $clog2(CMD_W);
  localparam int unsigned DC_W  = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BC_W-1:0]   bcnt_q;
  logic [DC_W-1:0]   dcnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CMD_W-1:0]  cmd_word;
  logic [DATA_W-1:0] shreg_nx;

  assign cmd_word = {1'b1, READ_OP, addr_q};
  assign shreg_nx = {shreg_q[DATA_W-2:0], do_i};
  assign busy_o   = (state_q != ST_IDLE);
  assign launch_o = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      bcnt_q       <= '0;
      dcnt_q       <= '0;
      shreg_q      <= '0;
      cs_o         <= 1'b0;
      sk_o         <= 1'b0;
      di_o         <= 1'b0;
      done_o       <= 1'b0;
      word_valid_o <= 1'b0;
      word_addr_o  <= '0;
      word_data_o  <= '0;
    end else begin
      word_valid_o <= 1'b0;
      if (launch_o) begin
        state_q <= ST_SEL;
        addr_q  <= '0;
        done_o  <= 1'b0;
      end else if (tick_i) begin
        unique case (state_q)
          ST_SEL: begin
            cs_o    <= 1'b1;
            bcnt_q  <= BC_W'(CMD_W - 1);
            state_q <= ST_CMD_SET;
          end
          ST_CMD_SET: begin
            di_o    <= cmd_word[bcnt_q];
            state_q <= ST_CMD_HI;
          end
          ST_CMD_HI: begin
            sk_o    <= 1'b1;
            state_q <= ST_CMD_LO;
          end
          ST_CMD_LO: begin
            sk_o <= 1'b0;
            if (bcnt_q == '0) begin
              dcnt_q  <= DC_W'(DATA_W - 1);
              state_q <= ST_DAT_HI;
            end else begin
              bcnt_q  <= bcnt_q - 1'b1;
              state_q <= ST_CMD_SET;
            end
          end
          ST_DAT_HI: begin
            sk_o    <= 1'b1;
            state_q <= ST_DAT_LO;
          end
          ST_DAT_LO: begin
            // sample before the clock falls
            sk_o    <= 1'b0;
            shreg_q <= shreg_nx;
            if (dcnt_q == '0) begin
              word_valid_o <= 1'b1;
              word_addr_o  <= addr_q;
              word_data_o  <= shreg_nx;
              state_q      <= ST_END_DROP;
            end else begin
              dcnt_q  <= dcnt_q - 1'b1;
              state_q <= ST_DAT_HI;
            end
          end
          ST_END_DROP: begin
            cs_o    <= 1'b0;
            di_o    <= 1'b0;
            state_q <= ST_END_HI;
          end
          ST_END_HI: begin
            sk_o    <= 1'b1;
            state_q <= ST_END_LO;
          end
          ST_END_LO: begin
            sk_o <= 1'b0;
            if (addr_q == LAST_ADDR) begin
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_SEL;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uwr_sum_check.sv
module uwr_sum_check #(
  parameter int unsigned       DATA_W    = 16,
  parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              match_o
);
  logic [DATA_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else if (clear_i) sum_q <= '0;
    else if (add_i) sum_q <= sum_q + data_i;
  end

  assign match_o = (sum_q == SIGNATURE);
endmodule

// File: rtl/uwire_eeprom_reader.sv
module uwire_eeprom_reader #(
  parameter int unsigned       STEP_DIV  = 50,
  parameter int unsigned       ADDR_W    = 6,
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       NUM_WORDS = 64,
  parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              eep_do_i,
  output logic              eep_cs_o,
  output logic              eep_sk_o,
  output logic              eep_di_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              checksum_ok_o,
  output logic              word_valid_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [DATA_W-1:0] word_data_o
);
  logic tick;
  logic launch;
  logic sum_match;

  uwr_step_timer #(.STEP_DIV(STEP_DIV)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  uwr_frame_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_WORDS (NUM_WORDS)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .tick_i       (tick),
    .do_i         (eep_do_i),
    .busy_o       (busy_o),
    .launch_o     (launch),
    .cs_o         (eep_cs_o),
    .sk_o         (eep_sk_o),
    .di_o         (eep_di_o),
    .done_o       (done_o),
    .word_valid_o (word_valid_o),
    .word_addr_o  (word_addr_o),
    .word_data_o  (word_data_o)
  );

  uwr_sum_check #(
    .DATA_W    (DATA_W),
    .SIGNATURE (SIGNATURE)
  ) i_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (launch),
    .add_i   (word_valid_o),
    .data_i  (word_data_o),
    .match_o (sum_match)
  );

  assign checksum_ok_o = done_o && sum_match;
endmodule

// File: rtl/uwr_checker.sv
module uwr_checker #(
  parameter int unsigned STEP_DIV = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cs_i,
  input logic sk_i,
  input logic di_i,
  input logic busy_i,
  input logic done_i,
  input logic ok_i,
  input logic valid_i
);
  localparam int unsigned HW = $clog2(STEP_DIV + 1) + 1;
  localparam logic [HW-1:0] HOLD_MAX = HW'(STEP_DIV);

  logic [2:0]    pins;
  logic [2:0]    pins_q;
  logic [HW-1:0] hold_q;

  assign pins = {cs_i, sk_i, di_i};

  // run length of the previous pin level, in sampled cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= '0;
      hold_q <= '0;
    end else begin
      pins_q <= pins;
      if (pins != pins_q) hold_q <= HW'(1);
      else if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
    end
  end

  a_r1_idle_pins_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!cs_i && !sk_i && !di_i));

  a_r5_step_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins != pins_q) |-> (hold_q >= HOLD_MAX));

  a_r4_cs_drop_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_i) |-> (!sk_i && !di_i));

  a_r6_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  a_r6_valid_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (busy_i && cs_i));

  a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  a_r7_ok_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_i |-> done_i);

  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> (busy_i || done_i));
endmodule

bind uwire_eeprom_reader uwr_checker #(.STEP_DIV(STEP_DIV)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .cs_i    (eep_cs_o),
  .sk_i    (eep_sk_o),
  .di_i    (eep_di_o),
  .busy_i  (busy_o),
  .done_i  (done_o),
  .ok_i    (checksum_ok_o),
  .valid_i (word_valid_o)
);

// File: tb/test_uwire_eeprom_reader.sv
module test_uwire_eeprom_reader;
  localparam int DIV   = 3;
  localparam int NW    = 64;
  localparam int FRAME = 63;
  localparam int TOTAL = NW * FRAME;
  localparam logic [15:0] SIG = 16'hBABA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic eep_do = 1'b0;
  logic eep_cs, eep_sk, eep_di;
  logic busy, done, ok, valid;
  logic [5:0]  waddr;
  logic [15:0] wdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uwire_eeprom_reader #(.STEP_DIV(DIV)) i_uwire_eeprom_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .eep_do_i(eep_do),
    .eep_cs_o(eep_cs), .eep_sk_o(eep_sk), .eep_di_o(eep_di),
    .busy_o(busy), .done_o(done), .checksum_ok_o(ok),
    .word_valid_o(valid), .word_addr_o(waddr), .word_data_o(wdata)
  );

  // behavioural serial memory
  logic [15:0] mem [NW];
  int dev_state = 0;
  int dev_cnt = 0;
  int dev_idx = 0;
  logic [7:0] dev_cmd = '0;
  logic [5:0] dev_addr = '0;

  always @(posedge eep_sk) begin
    if (!eep_cs) dev_state = 0;
    else begin
      case (dev_state)
        0: if (eep_di) begin dev_state = 1; dev_cnt = 0; end
        1: begin
          dev_cmd = {dev_cmd[6:0], eep_di};
          dev_cnt++;
          if (dev_cnt == 8) begin
            if (dev_cmd[7:6] == 2'b10) begin
              dev_addr = dev_cmd[5:0]; dev_idx = 15; dev_state = 2;
            end else dev_state = 3;
          end
        end
        2: begin
          eep_do = mem[dev_addr][dev_idx];
          if (dev_idx == 0) dev_state = 3; else dev_idx--;
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cmd_bit(int w, int b);
    if (b < 2) return 1;
    if (b == 2) return 0;
    return (w >> (8 - b)) & 1;
  endfunction

  // expected {cs,sk,di} after n applied steps
  function automatic int exp_pins(int n);
    int w, p, k;
    if (n == 0) return 0;
    w = (n - 1) / FRAME;
    p = (n - 1) % FRAME;
    if (p == 0) return 4;
    if (p <= 27) begin
      k = p - 1;
      return 4 + (((k % 3) == 1) ? 2 : 0) + cmd_bit(w, k / 3);
    end
    if (p <= 59) return 4 + ((((p - 28) % 2) == 0) ? 2 : 0) + (w & 1);
    if (p == 61) return 2;
    return 0;
  endfunction

  function automatic string region_tag(int n);
    int p;
    if (n == 0) return "R2";
    p = (n - 1) % FRAME;
    if (p <= 27) return "R2";
    if (p <= 59) return "R3";
    return "R4";
  endfunction

  task automatic sweep(input int poke_at, input bit first_after_done);
    logic [15:0] sum = '0;
    bit sum_ok;
    for (int i = 0; i < NW; i++) sum = sum + mem[i];
    sum_ok = (sum == SIG);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (first_after_done) begin
      chk(done == 1'b0, "R10", "done cleared", done, 0);
      chk(ok == 1'b0, "R10", "ok cleared", ok, 0);
    end
    for (int m = 0; m <= TOTAL * DIV + 3; m++) begin
      int n, ep, ap, w;
      bit ev;
      n  = (m / DIV > TOTAL) ? TOTAL : m / DIV;
      ep = exp_pins(n);
      ap = {29'd0, eep_cs, eep_sk, eep_di};
      start = (m == poke_at);
      if (m % DIV != 0) chk(ap == ep, "R5", "pins held", ap, ep);
      else chk(ap == ep, region_tag(n), "pins", ap, ep);
      if (poke_at > 0 && m == poke_at + 70 * DIV)
        chk(ap == ep, "R9", "pins after ignored start", ap, ep);
      chk(busy == (n < TOTAL), "R8", "busy", busy, n < TOTAL);
      chk(done == (n >= TOTAL), "R8", "done", done, n >= TOTAL);
      ev = (m % DIV == 0) && n >= 1 && ((n - 1) % FRAME == 59);
      chk(valid == ev, "R6", "word_valid", valid, ev);
      if (ev) begin
        w = (n - 1) / FRAME;
        chk(int'(waddr) == w, "R2", "word address order", waddr, w);
        chk(wdata == mem[w], "R3", "word data", wdata, mem[w]);
      end
      chk(ok == ((n >= TOTAL) && sum_ok), "R7", "checksum_ok", ok,
          (n >= TOTAL) && sum_ok);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] acc;
    repeat (3) @(negedge clk);
    chk({eep_cs, eep_sk, eep_di} == 3'b000, "R1", "pins in reset",
        {eep_cs, eep_sk, eep_di}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({eep_cs, eep_sk, eep_di} == 3'b000, "R1", "idle pins",
        {eep_cs, eep_sk, eep_di}, 0);
    chk({busy, done, ok, valid} == 4'b0000, "R1", "idle flags",
        {busy, done, ok, valid}, 0);

    // passing contents
    acc = '0;
    for (int i = 0; i < NW - 1; i++) begin
      mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      acc = acc + mem[i];
    end
    mem[NW-1] = SIG - acc;
    sweep(0, 1'b0);

    // failing contents, with a start pulse during the sweep
    mem[NW-1] = mem[NW-1] + 16'd1;
    sweep(500, 1'b1);

    // wrapping sum of heavy words
    acc = '0;
    for (int i = 0; i < NW - 1; i++) begin
      mem[i] = (i % 2 == 0) ? 16'hFFFF : 16'h8001;
      acc = acc + mem[i];
    end
    mem[NW-1] = SIG - acc;
    sweep(0, 1'b1);

    repeat (5) @(negedge clk);
    chk({eep_cs, eep_sk, eep_di} == 3'b000, "R1", "idle pins after sweep",
        {eep_cs, eep_sk, eep_di}, 0);
    chk(done && ok, "R8", "done held", {done, ok}, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule